// File: doc/BRIEF.md
# CPU/DMA Shared Bus Arbiter

This block decides which of two masters, a processor port or a DMA engine, drives a single shared memory bus. Each master raises a request; the arbiter answers with a registered, one-hot grant and a bus select line that steers the shared address and data multiplexer. Ownership changes only when the current holder reaches a beat boundary. Every hand-over leaves the bus undriven for a configurable number of cycles (`GAP_CYCLES`, default 1).

A mode input sets how long the DMA keeps the bus. In burst mode the DMA holds the bus until the beat that carries its block-end marker completes, so a block finishes as fast as possible even while the processor waits. In cycle-stealing mode the DMA gives the bus up after each finished beat whenever the processor wants it, which bounds processor latency at the cost of DMA throughput. The mode is captured when the DMA is granted and applies for that tenure. When both masters compete at an arbitration point, the one that was not served last wins, so neither starves.

Top module: `bus_share_arb`

## Requirements
- R1: `cpuGnt` and `dmaGnt` are never high together, and both are low while `rstN` is low.
- R2: From an idle bus, a master that requests alone is granted at the first rising clock edge that sees its request.
- R3: When both masters request at an idle arbitration point, the master not granted last wins. After reset the processor wins the first such tie.
- R4: A granted processor keeps the bus while `cpuReq` is high and `cpuBeatDone` is low.
- R5: A DMA granted with `burstMode`=1 keeps the bus, even while `cpuReq` is high, until an edge where `dmaBeatDone` and `dmaBlockEnd` are both high (or `dmaReq` falls).
- R6: A DMA granted with `burstMode`=0 loses the grant at the edge where `dmaBeatDone` is high and `cpuReq` is high, and the processor is granted after the idle gap.
- R7: A change of owner leaves both grants low for exactly `GAP_CYCLES` cycles (one by default). A grant never passes directly from one master to the other.
- R8: At a beat boundary where only the current owner is still requesting, its grant stays high without interruption.
- R9: `burstMode` is sampled at the edge that grants the DMA. Changing it during a tenure has no effect on that tenure.
- R10: `busSel` is 1 while the DMA is granted and 0 while the processor is granted. It keeps its last value while the bus is idle and is 0 after reset.
- R11: When the owner releases the bus and no master is requesting, both grants are low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor bus request |
| cpuBeatDone | input | 1 | Processor access completes this cycle |
| dmaReq | input | 1 | DMA bus request |
| dmaBeatDone | input | 1 | DMA beat completes this cycle |
| dmaBlockEnd | input | 1 | Current DMA beat is the last of its block |
| burstMode | input | 1 | 1 = DMA holds bus for a block, 0 = releases per beat |
| cpuGnt | output | 1 | Processor owns the bus |
| dmaGnt | output | 1 | DMA owns the bus |
| busSel | output | 1 | Mux select: 1 routes the DMA, 0 the processor |

## Verification
On every cycle the assertions check that the grants stay exclusive, that no grant passes directly between masters, that `busSel` matches the owner, that a sole requester is granted from idle one cycle later, and that each policy's hold and release rule is obeyed. Only the bench's scenarios show the exact alternation period under continuous contention, the hold length across swept burst sizes with stalled beats, and that a mode change during a tenure is ignored until the next grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GAP  = 2'd2
  } arbState_t;

  // strobes from control to datapath, applied at the next edge
  typedef struct packed {
    logic grantCpu;
    logic grantDma;
    logic dropBus;
  } arbStrobe_t;
endpackage

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter bit TIE_DMA_FIRST = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobe,
  input  logic       burstMode,
  output logic       cpuGnt,
  output logic       dmaGnt,
  output logic       busSel,
  output logic       lastDma,
  output logic       burstHeld
);
  // lastDma=1 makes the processor win the next tie
  localparam logic LAST_RESET = ~TIE_DMA_FIRST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuGnt    <= 1'b0;
      dmaGnt    <= 1'b0;
      busSel    <= 1'b0;
      lastDma   <= LAST_RESET;
      burstHeld <= 1'b0;
    end else if (strobe.grantCpu) begin
      cpuGnt  <= 1'b1;
      dmaGnt  <= 1'b0;
      busSel  <= 1'b0;
      lastDma <= 1'b0;
    end else if (strobe.grantDma) begin
      cpuGnt    <= 1'b0;
      dmaGnt    <= 1'b1;
      busSel    <= 1'b1;
      lastDma   <= 1'b1;
      burstHeld <= burstMode;
    end else if (strobe.dropBus) begin
      cpuGnt <= 1'b0;
      dmaGnt <= 1'b0;
    end
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuGnt && dmaGnt));
  a_r10_sel_dma: assert property (@(posedge clk) disable iff (!rstN)
    dmaGnt |-> busSel);
  a_r10_sel_cpu: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt |-> !busSel);
  a_r7_no_cpu_to_dma: assert property (@(posedge clk) disable iff (!rstN)
    cpuGnt |=> !dmaGnt);
  a_r7_no_dma_to_cpu: assert property (@(posedge clk) disable iff (!rstN)
    dmaGnt |=> !cpuGnt);
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuBeatDone,
  input  logic       dmaReq,
  input  logic       dmaBeatDone,
  input  logic       dmaBlockEnd,
  input  logic       cpuGnt,
  input  logic       dmaGnt,
  input  logic       lastDma,
  input  logic       burstHeld,
  output arbStrobe_t strobe
);
  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  arbState_t state, nextState;
  logic gapToDma, nextGapToDma;
  logic loadGap, gapDone;
  logic cpuEdge, dmaEdge, atBoundary, selfReq, otherReq, targetReq;

  assign cpuEdge    = cpuBeatDone || !cpuReq;
  assign dmaEdge    = !dmaReq || (dmaBeatDone && (!burstHeld || dmaBlockEnd));
  assign atBoundary = cpuGnt ? cpuEdge : dmaEdge;
  assign selfReq    = cpuGnt ? cpuReq : dmaReq;
  assign otherReq   = cpuGnt ? dmaReq : cpuReq;
  assign targetReq  = gapToDma ? dmaReq : cpuReq;

  generate
    if (GAP_CYCLES > 1) begin : g_gapCount
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk) begin
        if (!rstN)             gapCnt <= '0;
        else if (loadGap)      gapCnt <= GAP_W'(GAP_CYCLES - 1);
        else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      end
      assign gapDone = (gapCnt == '0);
    end else begin : g_gapSingle
      assign gapDone = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe       = '0;
    nextState    = state;
    nextGapToDma = gapToDma;
    loadGap      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq && dmaReq) begin
          if (lastDma) strobe.grantCpu = 1'b1;
          else         strobe.grantDma = 1'b1;
          nextState = ST_HOLD;
        end else if (cpuReq) begin
          strobe.grantCpu = 1'b1;
          nextState = ST_HOLD;
        end else if (dmaReq) begin
          strobe.grantDma = 1'b1;
          nextState = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (atBoundary) begin
          if (otherReq) begin
            strobe.dropBus = 1'b1;
            nextGapToDma   = cpuGnt;
            loadGap        = 1'b1;
            nextState      = ST_GAP;
          end else if (selfReq) begin
            // re-arbitration won by the same owner; refresh its grant
            if (cpuGnt) strobe.grantCpu = 1'b1;
            else        strobe.grantDma = 1'b1;
          end else begin
            strobe.dropBus = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (gapDone) begin
          if (targetReq) begin
            if (gapToDma) strobe.grantDma = 1'b1;
            else          strobe.grantCpu = 1'b1;
            nextState = ST_HOLD;
          end else if (cpuReq || dmaReq) begin
            if (gapToDma) strobe.grantCpu = 1'b1;
            else          strobe.grantDma = 1'b1;
            nextState = ST_HOLD;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapToDma <= 1'b0;
    end else begin
      state    <= nextState;
      gapToDma <= nextGapToDma;
    end
  end

  a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && (cpuReq || dmaReq)) |=> (cpuGnt || dmaGnt));
  a_r3_tie_to_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cpuReq && dmaReq && lastDma) |=> cpuGnt);
  a_r4_cpu_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGnt && cpuReq && !cpuBeatDone) |=> cpuGnt);
  a_r5_burst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && burstHeld && dmaReq && !(dmaBeatDone && dmaBlockEnd)) |=> dmaGnt);
  a_r6_steal_release: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt && !burstHeld && dmaBeatDone && cpuReq) |=> (!dmaGnt && !cpuGnt));
  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuGnt || dmaGnt) && !cpuReq && !dmaReq) |=> (!cpuGnt && !dmaGnt));
endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb
  import arb_pkg::*;
#(
  parameter int GAP_CYCLES    = 1,
  parameter bit TIE_DMA_FIRST = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic cpuReq,
  input  logic cpuBeatDone,
  input  logic dmaReq,
  input  logic dmaBeatDone,
  input  logic dmaBlockEnd,
  input  logic burstMode,
  output logic cpuGnt,
  output logic dmaGnt,
  output logic busSel
);
  arbStrobe_t strobe;
  logic lastDma, burstHeld;

  arb_ctrl #(.GAP_CYCLES(GAP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuBeatDone(cpuBeatDone),
    .dmaReq(dmaReq), .dmaBeatDone(dmaBeatDone), .dmaBlockEnd(dmaBlockEnd),
    .cpuGnt(cpuGnt), .dmaGnt(dmaGnt),
    .lastDma(lastDma), .burstHeld(burstHeld),
    .strobe(strobe)
  );

  arb_dpath #(.TIE_DMA_FIRST(TIE_DMA_FIRST)) uDpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .burstMode(burstMode),
    .cpuGnt(cpuGnt), .dmaGnt(dmaGnt), .busSel(busSel),
    .lastDma(lastDma), .burstHeld(burstHeld)
  );
endmodule

// File: tb/sim_bus_share_arb.sv
module sim_bus_share_arb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 0, cpuBeatDone = 0, dmaReq = 0, dmaBeatDone = 0;
  logic dmaBlockEnd = 0, burstMode = 0;
  logic cpuGnt, dmaGnt, busSel;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  bus_share_arb u0 (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuBeatDone(cpuBeatDone),
    .dmaReq(dmaReq), .dmaBeatDone(dmaBeatDone), .dmaBlockEnd(dmaBlockEnd),
    .burstMode(burstMode),
    .cpuGnt(cpuGnt), .dmaGnt(dmaGnt), .busSel(busSel)
  );

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic clearIn();
    cpuReq = 0; cpuBeatDone = 0; dmaReq = 0;
    dmaBeatDone = 0; dmaBlockEnd = 0; burstMode = 0;
  endtask

  task automatic doReset();
    clearIn();
    rstN = 0;
    tick(); tick();
    rstN = 1;
  endtask

  task automatic expGnt(string tag, logic expC, logic expD);
    checks++;
    if (cpuGnt !== expC || dmaGnt !== expD) begin
      errors++;
      $display("FAIL %s: grants cpu/dma actual=%b%b expected=%b%b",
               tag, cpuGnt, dmaGnt, expC, expD);
    end
  endtask

  task automatic expSel(string tag, logic expS);
    checks++;
    if (busSel !== expS) begin
      errors++;
      $display("FAIL %s: busSel actual=%b expected=%b", tag, busSel, expS);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 / R10: reset state
    doReset();
    expGnt("R1 reset", 0, 0);
    expSel("R10 reset", 0);

    // R2, R4, R11: processor alone
    cpuReq = 1; tick();
    expGnt("R2 cpu alone", 1, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      expGnt("R4 cpu mid-beat hold", 1, 0);
    end
    cpuReq = 0; tick();
    expGnt("R11 cpu release idle", 0, 0);
    // R2, R10: DMA alone, select holds while idle
    dmaReq = 1; tick();
    expGnt("R2 dma alone", 0, 1);
    expSel("R10 dma owner", 1);
    dmaReq = 0; tick();
    expGnt("R11 dma release idle", 0, 0);
    expSel("R10 idle hold", 1);

    // R3: ties from idle alternate, processor first after reset
    doReset();
    for (int k = 0; k < 6; k++) begin
      cpuReq = 1; dmaReq = 1; tick();
      expGnt("R3 tie alternation", (k % 2) == 0, (k % 2) == 1);
      cpuReq = 0; dmaReq = 0; tick();
      expGnt("R11 both drop", 0, 0);
    end

    // R6, R7, R10, R3: continuous contention, cycle stealing, period 4
    doReset();
    cpuReq = 1; dmaReq = 1; burstMode = 0;
    for (int i = 0; i < 16; i++) begin
      cpuBeatDone = cpuGnt;
      dmaBeatDone = dmaGnt;
      tick();
      expGnt("R6 R7 steal pattern", (i % 4) == 0, (i % 4) == 2);
      expSel("R10 steal select", (i % 4) >= 2);
    end

    // R5, R7: burst sweep over block lengths with a stall before each beat
    for (int len = 1; len <= 5; len++) begin
      doReset();
      dmaReq = 1; burstMode = 1; tick();
      expGnt("R5 burst grant", 0, 1);
      cpuReq = 1;
      for (int b = 0; b < len; b++) begin
        dmaBeatDone = 0; dmaBlockEnd = 0; tick();
        expGnt("R5 burst stall hold", 0, 1);
        dmaBeatDone = 1; dmaBlockEnd = (b == len - 1); tick();
        if (b < len - 1) expGnt("R5 burst beat hold", 0, 1);
        else             expGnt("R7 burst end gap", 0, 0);
      end
      dmaBeatDone = 0; dmaBlockEnd = 0; tick();
      expGnt("R7 cpu after gap", 1, 0);
      expSel("R10 cpu select", 0);
    end

    // R9: mode captured at grant
    doReset();
    dmaReq = 1; burstMode = 1; tick();
    expGnt("R9 burst grant", 0, 1);
    burstMode = 0; cpuReq = 1; dmaBeatDone = 1; dmaBlockEnd = 0; tick();
    expGnt("R9 late steal ignored", 0, 1);
    dmaBlockEnd = 1; tick();
    expGnt("R9 block end releases", 0, 0);
    dmaBeatDone = 0; dmaBlockEnd = 0; tick();
    expGnt("R9 cpu follows", 1, 0);
    doReset();
    dmaReq = 1; burstMode = 0; tick();
    expGnt("R9 steal grant", 0, 1);
    burstMode = 1; cpuReq = 1; dmaBeatDone = 1; tick();
    expGnt("R9 late burst ignored", 0, 0);

    // R8: boundary with sole requester keeps the grant
    doReset();
    dmaReq = 1; tick();
    expGnt("R2 dma grant", 0, 1);
    dmaBeatDone = 1;
    for (int k = 0; k < 4; k++) begin
      tick();
      expGnt("R8 dma sole continue", 0, 1);
    end
    doReset();
    cpuReq = 1; tick();
    cpuBeatDone = 1;
    for (int k = 0; k < 4; k++) begin
      tick();
      expGnt("R8 cpu sole continue", 1, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule